// File: doc/BRIEF.md
# Multi-Rate Serial Clock Enable Generator

This block makes the timing enables for one full-duplex serial channel. It runs from a 3.6864 MHz reference clock and produces, for the receive side and the transmit side each, a single-cycle enable at sixteen times the bit rate and a second enable at the bit rate itself. Each side picks its own source and rate, so the two directions can run at different speeds.

With the internal source, a 5-bit rate code picks one of 19 standard rates between 50 and 76 800 baud. The divisor for each code is worked out when the design is elaborated, as the nearest integer to 3 686 400 / (16 × rate). The divider reloads as soon as the code changes. With an external source, the serial clock pin is synchronised and its rising edges are used. Each edge gives one oversampling enable, and the bit enable then comes either from every sixteenth edge (asynchronous use) or from every edge (synchronous use, one bit per external clock).

Top module: `serial_rate_gen`

## Requirements
- R1: While `rst_n` is low, all four enable outputs are 0.
- R2: In internal mode (mode code 2'b00), successive oversampling enables are exactly D reference cycles apart. For rate codes 0 to 18, D is 4608, 3072, 2095, 1713, 1536, 1152, 768, 384, 219, 192, 128, 115, 96, 48, 32, 24, 12, 6, 3, which are the rates 50, 75, 110, 134.5, 150, 200, 300, 600, 1050, 1200, 1800, 2000, 2400, 4800, 7200, 9600, 19200, 38400, 76800.
- R3: In internal mode, a rate code of 19 or more produces no enables on that side.
- R4: Each oversampling enable is high for one cycle only, as long as the mode does not change.
- R5: In internal mode and in external x16 mode (mode code 2'b01), the bit enable rises only together with the oversampling enable, once every 16 oversampling enables.
- R6: When the rate code changes, the divider reloads at the first clock edge that sees the new code. The next oversampling enable comes at edge D+1 counted from that edge, with D the new divisor, and no enable comes before it.
- R7: In external x16 mode, each rising edge of `sclk` gives one oversampling enable. The enable rises after the third reference clock edge that sees `sclk` high.
- R8: In external x1 mode (mode code 2'b10), each rising edge of `sclk` gives one oversampling enable and one bit enable in the same cycle.
- R9: With mode code 2'b11, that side produces no enables, even while `sclk` toggles.
- R10: The receive and transmit sides take their rate codes and modes on their own, so different rates run on the two sides at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.6864 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | External serial clock, asynchronous to `clk` |
| rx_mode | input | 2 | Receive source: 00 internal, 01 external x16, 10 external x1, 11 off |
| rx_rate_sel | input | 5 | Receive rate code, 0 to 18 |
| tx_mode | input | 2 | Transmit source, same encoding as `rx_mode` |
| tx_rate_sel | input | 5 | Transmit rate code, 0 to 18 |
| rx_os_en | output | 1 | Receive oversampling (16x) enable pulse |
| rx_bit_en | output | 1 | Receive bit-rate enable pulse |
| tx_os_en | output | 1 | Transmit oversampling (16x) enable pulse |
| tx_bit_en | output | 1 | Transmit bit-rate enable pulse |

## Verification
The single-cycle property assumes the mode input does not change in the cycle after an enable, and it assumes that `sclk` stays high and low for at least one reference cycle each. The stimulus changes mode only during quiet intervals and drives `sclk` with four-cycle high and low phases. The checks for undefined codes and for the off mode rely on the code and mode being steady since the cycle before. The stimulus holds each setting for thousands of cycles and starts counting only a few cycles after each change.

// File: rtl/brg_pkg.sv
package brg_pkg;

  localparam int unsigned REF_HZ     = 3686400;
  localparam int unsigned OVERSAMPLE = 16;
  localparam int unsigned NUM_RATES  = 19;
  localparam int unsigned SEL_W      = 5;
  localparam int unsigned PHASE_W    = $clog2(OVERSAMPLE);

  typedef enum logic [1:0] {
    SRC_INT   = 2'b00,
    SRC_EXT16 = 2'b01,
    SRC_EXT1  = 2'b10,
    SRC_OFF   = 2'b11
  } src_mode_e;

  // Standard rates in tenths of a baud, indexed by rate code.
  function automatic int unsigned rate_deci(int unsigned idx);
    case (idx)
      0:       return 500;
      1:       return 750;
      2:       return 1100;
      3:       return 1345;
      4:       return 1500;
      5:       return 2000;
      6:       return 3000;
      7:       return 6000;
      8:       return 10500;
      9:       return 12000;
      10:      return 18000;
      11:      return 20000;
      12:      return 24000;
      13:      return 48000;
      14:      return 72000;
      15:      return 96000;
      16:      return 192000;
      17:      return 384000;
      default: return 768000;
    endcase
  endfunction

  // Rounded divisor from reference clock to the 16x rate.
  function automatic int unsigned rate_div(int unsigned idx);
    int unsigned num;
    num = REF_HZ * 10 / OVERSAMPLE;
    return (num + rate_deci(idx) / 2) / rate_deci(idx);
  endfunction

  localparam int unsigned DIV_W = $clog2(rate_div(0) + 1);

endpackage

// File: rtl/brg_edge_sync.sv
module brg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic rise
);

  logic [STAGES:0] sh_q, sh_d;
  logic            rise_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-1:0], ext_in};
    rise_d = sh_q[STAGES-1] & ~sh_q[STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      rise <= 1'b0;
    end else begin
      sh_q <= sh_d;
      rise <= rise_d;
    end
  end

endmodule

// File: rtl/brg_divider.sv
module brg_divider
  import brg_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  input  logic          sel_ok,
  input  logic [DW-1:0] divisor,
  output logic          tick
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sel_q;
  logic          tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!sel_ok) begin
      cnt_d = '0;
    end else if (sel != sel_q) begin
      cnt_d = divisor - 1'b1;
    end else if (cnt_q == '0) begin
      cnt_d  = divisor - 1'b1;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '1;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel;
      tick  <= tick_d;
    end
  end

endmodule

// File: rtl/brg_bitphase.sv
module brg_bitphase
  import brg_pkg::*;
#(
  parameter int unsigned OS = OVERSAMPLE,
  parameter int unsigned PW = PHASE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_pulse,
  input  logic direct,
  output logic bit_en
);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d   = os_pulse ? ph_q + 1'b1 : ph_q;
    bit_en = os_pulse && (direct || ph_q == PW'(OS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import brg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic [1:0]       rx_mode,
  input  logic [SEL_W-1:0] rx_rate_sel,
  input  logic [1:0]       tx_mode,
  input  logic [SEL_W-1:0] tx_rate_sel,
  output logic             rx_os_en,
  output logic             rx_bit_en,
  output logic             tx_os_en,
  output logic             tx_bit_en
);

  localparam int unsigned NDIR = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Divisor table computed at elaboration.
  logic [DIV_W-1:0] div_tab [NUM_RATES];
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tab
    assign div_tab[g] = DIV_W'(rate_div(g));
  end

  logic ext_rise;
  brg_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .ext_in (sclk),
    .rise   (ext_rise)
  );

  logic [1:0]       mode_v [NDIR];
  logic [SEL_W-1:0] sel_v  [NDIR];
  logic             os_v   [NDIR];
  logic             bit_v  [NDIR];

  assign mode_v[0] = rx_mode;
  assign mode_v[1] = tx_mode;
  assign sel_v[0]  = rx_rate_sel;
  assign sel_v[1]  = tx_rate_sel;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    src_mode_e        mode;
    logic [DIV_W-1:0] divisor;
    logic             sel_ok;
    logic             tick;
    logic             os_pulse;
    logic             direct;
    logic             bit_pulse;

    assign mode = src_mode_e'(mode_v[d]);

    always_comb begin
      divisor = '0;
      sel_ok  = 1'b0;
      for (int i = 0; i < NUM_RATES; i++) begin
        if (sel_v[d] == SEL_W'(i)) begin
          divisor = div_tab[i];
          sel_ok  = 1'b1;
        end
      end
    end

    brg_divider i_div (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .sel     (sel_v[d]),
      .sel_ok  (sel_ok),
      .divisor (divisor),
      .tick    (tick)
    );

    always_comb begin
      case (mode)
        SRC_INT:             os_pulse = tick;
        SRC_EXT16, SRC_EXT1: os_pulse = ext_rise;
        default:             os_pulse = 1'b0;
      endcase
      direct = (mode == SRC_EXT1);
    end

    brg_bitphase i_phase (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .os_pulse (os_pulse),
      .direct   (direct),
      .bit_en   (bit_pulse)
    );

    assign os_v[d]  = os_pulse;
    assign bit_v[d] = bit_pulse;
  end

  assign rx_os_en  = os_v[0];
  assign rx_bit_en = bit_v[0];
  assign tx_os_en  = os_v[1];
  assign tx_bit_en = bit_v[1];

endmodule

// File: rtl/brg_checker.sv
module brg_checker
  import brg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic [1:0]       rx_mode,
  input logic [SEL_W-1:0] rx_rate_sel,
  input logic [1:0]       tx_mode,
  input logic [SEL_W-1:0] tx_rate_sel,
  input logic             rx_os_en,
  input logic             rx_bit_en,
  input logic             tx_os_en,
  input logic             tx_bit_en
);

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!rx_os_en && !rx_bit_en && !tx_os_en && !tx_bit_en));

  assert_bad_code_R3_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rx_mode == 2'b00 && $past(rx_rate_sel) >= SEL_W'(NUM_RATES)) |-> !rx_os_en);

  assert_bad_code_R3_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tx_mode == 2'b00 && $past(tx_rate_sel) >= SEL_W'(NUM_RATES)) |-> !tx_os_en);

  assert_os_single_R4_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_os_en |=> (!rx_os_en || rx_mode != $past(rx_mode)));

  assert_os_single_R4_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_os_en |=> (!tx_os_en || tx_mode != $past(tx_mode)));

  assert_bit_with_os_R5_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_en |-> rx_os_en);

  assert_bit_with_os_R5_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_en |-> tx_os_en);

  assert_sync_bit_R8_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == 2'b10) |-> (rx_bit_en == rx_os_en));

  assert_sync_bit_R8_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode == 2'b10) |-> (tx_bit_en == tx_os_en));

  assert_off_quiet_R9_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == 2'b11) |-> (!rx_os_en && !rx_bit_en));

  assert_off_quiet_R9_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode == 2'b11) |-> (!tx_os_en && !tx_bit_en));

endmodule

bind serial_rate_gen brg_checker i_chk (.*);

// File: tb/test_serial_rate_gen.sv
module test_serial_rate_gen;

  localparam int unsigned NRATES = 19;
  localparam int unsigned EXP_DIV [NRATES] = '{
    4608, 3072, 2095, 1713, 1536, 1152, 768, 384, 219, 192,
    128, 115, 96, 48, 32, 24, 12, 6, 3};
  localparam int unsigned LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic [1:0] rx_mode = 2'b00;
  logic [4:0] rx_rate_sel = 5'd18;
  logic [1:0] tx_mode = 2'b00;
  logic [4:0] tx_rate_sel = 5'd18;
  logic       rx_os_en, rx_bit_en, tx_os_en, tx_bit_en;

  int n_checks = 0;
  int n_fails  = 0;
  int rx_os_n = 0, rx_bit_n = 0, tx_os_n = 0, tx_bit_n = 0;

  always #10 clk = ~clk;

  serial_rate_gen i_serial_rate_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .rx_mode     (rx_mode),
    .rx_rate_sel (rx_rate_sel),
    .tx_mode     (tx_mode),
    .tx_rate_sel (tx_rate_sel),
    .rx_os_en    (rx_os_en),
    .rx_bit_en   (rx_bit_en),
    .tx_os_en    (tx_os_en),
    .tx_bit_en   (tx_bit_en)
  );

  always @(negedge clk) begin
    if (rx_os_en)  rx_os_n++;
    if (rx_bit_en) rx_bit_n++;
    if (tx_os_en)  tx_os_n++;
    if (tx_bit_en) tx_bit_n++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rx_os(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!rx_os_en && k < LIMIT);
  endtask

  task automatic wait_tx_os(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!tx_os_en && k < LIMIT);
  endtask

  task automatic wait_rx_bit(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!rx_bit_en && k < 2 * LIMIT);
  endtask

  task automatic sclk_train(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected run to finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int k;
    int a0, a1, a2, a3;

    // R1: quiet during reset
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {28'd0, rx_os_en, rx_bit_en, tx_os_en, tx_bit_en}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2 / R6: walk the whole rate table on the receive side
    for (int g = 0; g < NRATES; g++) begin
      rx_rate_sel = 5'(g);
      wait_rx_os(k);
      check($sformatf("R6 reload delay code %0d", g), k, EXP_DIV[g] + 1);
      wait_rx_os(k);
      check($sformatf("R2 period code %0d", g), k, EXP_DIV[g]);
    end

    // R4: enable lasts one cycle at the fastest rate
    wait_rx_os(k);
    @(negedge clk);
    check("R4 single cycle", rx_os_en, 0);

    // R5: bit enable every 16 oversampling enables, with os_en
    rx_rate_sel = 5'd18;
    wait_rx_bit(k);
    wait_rx_bit(k);
    check("R5 bit period code 18", k, 48);
    check("R5 bit with os", rx_os_en, 1);
    @(negedge clk) rx_rate_sel = 5'd12;
    wait_rx_bit(k);
    wait_rx_bit(k);
    check("R5 bit period code 12", k, 1536);

    // R10: different rates on each side at once
    @(negedge clk);
    rx_rate_sel = 5'd18;
    tx_rate_sel = 5'd17;
    repeat (30) @(negedge clk);
    wait_rx_os(k);
    wait_rx_os(k);
    check("R10 rx period", k, 3);
    wait_tx_os(k);
    wait_tx_os(k);
    check("R10 tx period", k, 6);

    // R3: undefined rate codes stay quiet
    rx_rate_sel = 5'd19;
    tx_rate_sel = 5'd31;
    repeat (3) @(negedge clk);
    a0 = rx_os_n; a1 = rx_bit_n; a2 = tx_os_n; a3 = tx_bit_n;
    repeat (6000) @(negedge clk);
    check("R3 rx os code 19", rx_os_n - a0, 0);
    check("R3 rx bit code 19", rx_bit_n - a1, 0);
    check("R3 tx os code 31", tx_os_n - a2, 0);
    check("R3 tx bit code 31", tx_bit_n - a3, 0);

    // R7: latency from sclk rise to oversampling enable
    rx_mode = 2'b01;
    tx_mode = 2'b10;
    rx_rate_sel = 5'd18;
    tx_rate_sel = 5'd18;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    wait_rx_os(k);
    check("R7 edge latency", k, 3);
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (8) @(negedge clk);

    // R7 / R8: counting over 64 external clocks
    a0 = rx_os_n; a1 = rx_bit_n; a2 = tx_os_n; a3 = tx_bit_n;
    sclk_train(64);
    repeat (8) @(negedge clk);
    check("R7 x16 os count", rx_os_n - a0, 64);
    check("R5 x16 bit count", rx_bit_n - a1, 4);
    check("R8 x1 os count", tx_os_n - a2, 64);
    check("R8 x1 bit count", tx_bit_n - a3, 64);

    // R9: off mode ignores sclk
    rx_mode = 2'b11;
    tx_mode = 2'b11;
    repeat (3) @(negedge clk);
    a0 = rx_os_n; a1 = rx_bit_n; a2 = tx_os_n; a3 = tx_bit_n;
    sclk_train(20);
    repeat (8) @(negedge clk);
    check("R9 rx off os", rx_os_n - a0, 0);
    check("R9 rx off bit", rx_bit_n - a1, 0);
    check("R9 tx off os", tx_os_n - a2, 0);
    check("R9 tx off bit", tx_bit_n - a3, 0);

    // R1: reset again mid-run clears everything
    tx_mode = 2'b00;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", {28'd0, rx_os_en, rx_bit_en, tx_os_en, tx_bit_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule